// File: doc/BRIEF.md
# Token Bucket Port Rate Limiter

This block paces one transmit port with a signed token balance. Each clock the balance is credited with a replenish amount supplied on an input, and it is never raised above a burst ceiling. When a packet begins and the port is currently permitted, the balance is charged once for the whole packet. The charge has a fixed per-packet part, which covers framing overhead such as interframe gap, preamble and CRC, and a per-word part scaled by the number of 8-byte data words in the packet.

The packet cost and the burst limit are given in coarse units of 256 raw tokens. The word cost and the replenish amount are in raw tokens. Setting the word cost to zero turns the block into a pure packets-per-interval limiter. The send permit output is high whenever the balance is zero or positive. The port holds off new packets while it is low.

Top module: `port_rate_limiter`

## Requirements
- R1: While reset is asserted and right after it is released, the balance is zero and `send_ok` is 1.
- R2: `send_ok` is 1 exactly when the balance is greater than or equal to zero. A balance of exactly zero still permits sending.
- R3: A packet start that is accepted (`pkt_start` high while `send_ok` is 1) lowers the balance at that clock edge by `pkt_cost*256 + pkt_words*word_cost`.
- R4: On every clock edge the balance is credited with `refill`. The credited value is capped at `burst_lim*256`.
- R5: A `pkt_start` pulse arriving while `send_ok` is 0 is ignored: no charge is taken.
- R6: When `word_cost` is zero, the charge does not depend on `pkt_words`.
- R7: When a credit and an accepted charge fall on the same edge, the capped credit is applied first and the charge is subtracted from the capped result.
- R8: If `burst_lim` is lowered below the current balance, the balance is cut to the new ceiling at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_cost | input | PKT_W | Per-packet charge in units of 256 tokens |
| word_cost | input | WORD_W | Charge per 8-byte data word, in tokens |
| burst_lim | input | LIM_W | Balance ceiling in units of 256 tokens |
| refill | input | CRED_W | Tokens credited on every clock |
| pkt_start | input | 1 | One-cycle pulse marking the start of a packet |
| pkt_words | input | WCNT_W | Data word count of the starting packet |
| send_ok | output | 1 | Send permit, high while the balance is not negative |

## Verification
The bench builds the limiter with 8-bit costs, limit and refill, and a 4-bit word count. With these widths the largest possible charge, 255 coarse units plus 15 words of 255 tokens, can be applied against a full ceiling of 255 coarse units. Recovery from the resulting deficit then takes only a dozen or so clocks, so the full-width charge path, the cap and the zero boundary are all reached with short directed runs. Recovery times are predicted in closed form, as the number of refill edges needed to bring the deficit back to zero or above.

// File: rtl/port_rate_limiter.sv
module port_rate_limiter #(
  parameter int PKT_W  = 16,
  parameter int WORD_W = 16,
  parameter int WCNT_W = 11,
  parameter int LIM_W  = 16,
  parameter int CRED_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PKT_W-1:0]  pkt_cost,
  input  logic [WORD_W-1:0] word_cost,
  input  logic [LIM_W-1:0]  burst_lim,
  input  logic [CRED_W-1:0] refill,
  input  logic              pkt_start,
  input  logic [WCNT_W-1:0] pkt_words,
  output logic              send_ok
);

  localparam int PW    = PKT_W + 8;
  localparam int WW    = WORD_W + WCNT_W;
  localparam int LW    = LIM_W + 8;
  localparam int M1    = (PW > WW) ? PW : WW;
  localparam int M2    = (M1 > LW) ? M1 : LW;
  localparam int M3    = (M2 > CRED_W) ? M2 : CRED_W;
  localparam int ACC_W = M3 + 2;
  localparam int SUM_W = ACC_W + 1;

  logic signed [ACC_W-1:0] bal_q;
  logic signed [SUM_W-1:0] bal_ext, ceil_v, raised, filled, debit, next_bal;
  logic        [WW-1:0]    word_chg;
  logic        [SUM_W-1:0] charge;
  logic                    take;

  assign send_ok  = ~bal_q[ACC_W-1];
  assign take     = pkt_start & send_ok;

  assign bal_ext  = {bal_q[ACC_W-1], bal_q};
  assign ceil_v   = $signed({{(SUM_W-LW){1'b0}}, burst_lim, 8'h00});
  assign raised   = bal_ext + $signed({{(SUM_W-CRED_W){1'b0}}, refill});
  assign filled   = (raised > ceil_v) ? ceil_v : raised;

  assign word_chg = {{WCNT_W{1'b0}}, word_cost} * {{WORD_W{1'b0}}, pkt_words};
  assign charge   = {{(SUM_W-PW){1'b0}}, pkt_cost, 8'h00}
                  + {{(SUM_W-WW){1'b0}}, word_chg};
  assign debit    = take ? $signed(charge) : '0;
  assign next_bal = filled - debit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bal_q <= '0;
    else        bal_q <= next_bal[ACC_W-1:0];
  end

endmodule

// File: rtl/port_rate_limiter_chk.sv
module port_rate_limiter_chk #(
  parameter int ACC_W  = 20,
  parameter int LIM_W  = 16,
  parameter int CRED_W = 12,
  parameter int PKT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LIM_W-1:0]        burst_lim,
  input logic [CRED_W-1:0]       refill,
  input logic [PKT_W-1:0]        pkt_cost,
  input logic                    pkt_start,
  input logic                    send_ok,
  input logic signed [ACC_W-1:0] bal_q
);

  logic signed [ACC_W:0] cap, bal;
  assign cap = $signed({{(ACC_W+1-LIM_W-8){1'b0}}, burst_lim, 8'h00});
  assign bal = {bal_q[ACC_W-1], bal_q};

  assert_reset_permit_R1: assert property (@(posedge clk) !rst_n |-> send_ok);

  assert_permit_falls_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_ok) |-> $past(pkt_start));

  assert_accept_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ok && pkt_start && pkt_cost != 0 && refill == 0 && bal <= cap) |=> bal < $past(bal));

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bal <= $past(cap));

  assert_blocked_no_charge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !send_ok |=> bal >= $past(bal));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && refill == 0 && bal <= cap) |=> $stable(bal_q));

  assert_cut_to_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && refill == 0 && bal > cap) |=> bal == $past(cap));

endmodule

bind port_rate_limiter port_rate_limiter_chk #(
  .ACC_W(ACC_W), .LIM_W(LIM_W), .CRED_W(CRED_W), .PKT_W(PKT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_lim(burst_lim), .refill(refill),
  .pkt_cost(pkt_cost), .pkt_start(pkt_start), .send_ok(send_ok), .bal_q(bal_q)
);

// File: tb/test_port_rate_limiter.sv
module test_port_rate_limiter;
  localparam int PKT_W = 8, WORD_W = 8, WCNT_W = 4, LIM_W = 8, CRED_W = 8;

  logic clk = 0, rst_n = 0, pkt_start = 0;
  logic [PKT_W-1:0]  pkt_cost = 0;
  logic [WORD_W-1:0] word_cost = 0;
  logic [LIM_W-1:0]  burst_lim = 0;
  logic [CRED_W-1:0] refill = 0;
  logic [WCNT_W-1:0] pkt_words = 0;
  logic send_ok;

  int n_chk = 0, n_bad = 0, exp_bal = 0;
  bit done = 0;

  always #2 clk = ~clk;

  port_rate_limiter #(.PKT_W(PKT_W), .WORD_W(WORD_W), .WCNT_W(WCNT_W),
                      .LIM_W(LIM_W), .CRED_W(CRED_W)) i_port_rate_limiter (
    .clk(clk), .rst_n(rst_n), .pkt_cost(pkt_cost), .word_cost(word_cost),
    .burst_lim(burst_lim), .refill(refill), .pkt_start(pkt_start),
    .pkt_words(pkt_words), .send_ok(send_ok));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, model advanced, permit checked at next negedge
  task automatic step(input bit st, input int words, input string tag);
    int capv, filled, chg;
    pkt_start = st;
    pkt_words = WCNT_W'(words);
    @(posedge clk);
    capv   = int'(burst_lim) * 256;
    filled = exp_bal + int'(refill);
    if (filled > capv) filled = capv;
    chg = int'(pkt_cost) * 256 + words * int'(word_cost);
    exp_bal = (st && exp_bal >= 0) ? filled - chg : filled;
    @(negedge clk);
    pkt_start = 0;
    check(tag, int'(send_ok), (exp_bal >= 0) ? 1 : 0);
  endtask

  // counts edges with given refill until permit returns
  task automatic recover(input int exp_edges, input string tag);
    int n = 0;
    while (!send_ok && n < 1000) begin
      step(0, 0, tag);
      n++;
    end
    check(tag, n, exp_edges);
  endtask

  task automatic t_reset;
    check("R1", int'(send_ok), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(send_ok), 1);
  endtask

  task automatic t_basic_charge;
    burst_lim = 4; refill = 0; pkt_cost = 2; word_cost = 100;
    step(1, 6, "R3");
    check("R3", int'(send_ok), 0);
    refill = 100;
    recover(12, "R3");
  endtask

  task automatic t_cap_and_zero;
    refill = 200; burst_lim = 4;
    for (int i = 0; i < 20; i++) step(0, 0, "R4");
    refill = 0; pkt_cost = 4; word_cost = 0;
    step(1, 0, "R4");
    check("R2", int'(send_ok), 1);
    pkt_cost = 0; word_cost = 1;
    step(1, 1, "R2");
    check("R2", int'(send_ok), 0);
    refill = 1;
    recover(1, "R2");
  endtask

  task automatic t_blocked;
    refill = 0; pkt_cost = 0; word_cost = 1;
    step(1, 1, "R5");
    pkt_cost = 200; word_cost = 200;
    for (int i = 0; i < 4; i++) step(1, 15, "R5");
    refill = 1;
    recover(1, "R5");
  endtask

  task automatic t_no_word_cost;
    refill = 0; pkt_cost = 1; word_cost = 0;
    step(1, 1, "R6");
    refill = 64;
    recover(4, "R6");
    refill = 0;
    step(1, 15, "R6");
    refill = 64;
    recover(4, "R6");
  endtask

  task automatic t_same_edge;
    burst_lim = 4; refill = 200;
    for (int i = 0; i < 10; i++) step(0, 0, "R7");
    refill = 50; pkt_cost = 4; word_cost = 0;
    step(1, 0, "R7");
    refill = 0; pkt_cost = 0; word_cost = 1;
    step(1, 1, "R7");
    check("R7", int'(send_ok), 0);
    refill = 1;
    recover(1, "R7");
  endtask

  task automatic t_lower_limit;
    burst_lim = 8; refill = 250;
    for (int i = 0; i < 12; i++) step(0, 0, "R8");
    refill = 0; burst_lim = 1;
    step(0, 0, "R8");
    pkt_cost = 1; word_cost = 0;
    step(1, 0, "R8");
    check("R8", int'(send_ok), 1);
    pkt_cost = 0; word_cost = 1;
    step(1, 1, "R8");
    check("R8", int'(send_ok), 0);
    refill = 1;
    recover(1, "R8");
  endtask

  task automatic t_full_width;
    burst_lim = 255; refill = 255;
    for (int i = 0; i < 300; i++) step(0, 0, "R4");
    pkt_cost = 255; word_cost = 255; refill = 0;
    step(1, 15, "R3");
    check("R3", int'(send_ok), 0);
    refill = 255;
    recover(15, "R3");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_charge();
    t_cap_and_zero();
    t_blocked();
    t_no_word_cost();
    t_same_edge();
    t_lower_limit();
    t_full_width();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule